// File: doc/BRIEF.md
# T1 Per-Channel Payload Manipulator

This block sits in the transmit path of a T1 framer. The serial stream arrives one bit per strobe, with a position count alongside it. Position 0 is the frame bit. Positions 1 to 192 carry 24 eight-bit channels, most significant bit first. Each channel has an 8-bit control word and an 8-bit idle code, both held in a small control memory.

At the end of each channel the block builds the outgoing byte. It chooses among the channel's raw data, a loopback byte, the mu-law digital-milliwatt sequence, PRBS test data and the idle code, or it inverts bits of the raw data. It can then apply one of three zero code suppression rules. Because the whole channel is gathered before it is rewritten, the output stream trails the input by eight bit strobes.

A tap mode routes the incoming data to an external PRBS checker. The tap carries either the whole frame or only the channels marked for test. An unframed insertion mode replaces every bit of the frame, including the frame bit, with the PRBS stream.

Top module: `t1_payload_mod`

## Requirements
- R1: After reset `ser_out` and `tap_vld` are 0. Every control word is 0x00, every idle code is 0x7F, and the milliwatt index is 0.
- R2: State advances only on cycles with `bit_en` high. `ser_out` carries the bit captured eight strobes earlier, updated on the strobe edge, and holds on cycles without a strobe. `tap_vld` is high only in the cycle after a strobe.
- R3: Frame layout. `frm_pos` 0 is the frame bit, passed through unchanged unless R9 applies. `frm_pos` p in 1..192 is bit (p-1)%8 of channel (p-1)/8, with bit 0 being the MSB.
- R4: With `glb_en` low, all per-channel control and all test modes are off. The output equals the input delayed, and `tap_vld` stays 0.
- R5: Control word bits: [1:0] zero code suppression type, [2] loopback, [3] test, [4] magnitude invert, [5] milliwatt, [6] idle, [7] sign invert. Priority from highest: loopback (byte from `loop_in`), milliwatt, PRBS insertion (test bit set, framed mode, `tap_mode` low), idle code, inversion.
- R6: Sign invert flips the MSB. Magnitude invert flips the seven lower bits. The two are independent and may be combined.
- R7: Milliwatt substitution sends byte i of the sequence 0x1E, 0x0B, 0x0B, 0x1E, 0x9E, 0x8B, 0x8B, 0x9E in every channel that selects it. The index i advances by one, modulo 8, on the strobe at `frm_pos` 192.
- R8: In framed insertion with `nx56` high, bits 1 to 7 of a test channel come from `prbs_in`. The eighth bit (LSB) keeps the raw input bit.
- R9: With `glb_en` high, `tap_mode` low and `unframed` high, every output bit is the `prbs_in` bit of that slot, the frame bit included. No per-channel control applies.
- R10: Zero code suppression acts on the byte after substitution. Type 0 does nothing. Type 1 turns 0x00 into 0x02. Type 2 turns 0x00 into 0x01. Type 3 sets bit value 0x02 whenever the seven lower bits are zero (0x00 becomes 0x02, 0x80 becomes 0x82). It never applies to a byte taken from PRBS.
- R11: With `glb_en` and `tap_mode` high, `tap_dat` is the `ser_in` bit of the last strobe. `tap_vld` marks it when `unframed` is high, or else when that bit lies in a test channel, excluding the LSB when `nx56` is high. In tap mode the test bit does not alter the output.
- R12: A strobe on `cfg_we` writes `cfg_wdata` to the control word (`cfg_sel` 0) or the idle code (`cfg_sel` 1) of channel `cfg_ch`. Writes with `cfg_ch` of 24 or more change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One strobe per serial bit |
| frm_pos | input | 8 | Bit position in frame, 0..192 |
| ser_in | input | 1 | Serial payload in |
| loop_in | input | 1 | Loopback serial data, aligned with ser_in |
| prbs_in | input | 1 | PRBS generator bit for this slot |
| glb_en | input | 1 | Global enable for per-channel control |
| tap_mode | input | 1 | 1 routes data to the checker; 0 allows insertion |
| unframed | input | 1 | Test acts on the whole frame |
| nx56 | input | 1 | Fractional test: skip each channel's LSB |
| cfg_we | input | 1 | Control memory write strobe |
| cfg_sel | input | 1 | 0 control word, 1 idle code |
| cfg_ch | input | 5 | Channel to write |
| cfg_wdata | input | 8 | Write data |
| ser_out | output | 1 | Modified serial data, eight strobes later |
| tap_dat | output | 1 | Tapped data bit |
| tap_vld | output | 1 | Tap bit valid |

## Verification
The bench sets channels with several actions at once: loopback with milliwatt, test with idle, milliwatt with test, idle with sign invert. A wrong priority chain then shows up as the wrong byte. It runs eight frames of milliwatt so that every sequence entry appears; an index that advanced per channel or at the wrong position would put the wrong entries out. Zero code suppression is tried with 0x00 and 0x80 on test channels and on plain ones, which exposes a rule applied to PRBS data or a type 3 that only looks for 0x00. Strobe gaps, the frame bit in unframed insertion, the Nx56 LSB in both insertion and tap, and writes to channels 24 and above catch designs that shift on every clock, leave the frame bit alone, take the eighth bit from PRBS, or alias out-of-range writes onto real channels.

// File: rtl/t1_payload_mod.sv
module t1_payload_mod #(
  parameter int CHANNELS = 24,
  parameter logic [7:0] IDLE_RST = 8'h7F
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          bit_en,
  input  logic [$clog2(CHANNELS*8+1)-1:0] frm_pos,
  input  logic                          ser_in,
  input  logic                          loop_in,
  input  logic                          prbs_in,
  input  logic                          glb_en,
  input  logic                          tap_mode,
  input  logic                          unframed,
  input  logic                          nx56,
  input  logic                          cfg_we,
  input  logic                          cfg_sel,
  input  logic [$clog2(CHANNELS)-1:0]   cfg_ch,
  input  logic [7:0]                    cfg_wdata,
  output logic                          ser_out,
  output logic                          tap_dat,
  output logic                          tap_vld
);
  localparam int FRAME_BITS = CHANNELS*8 + 1;
  localparam int PW  = $clog2(FRAME_BITS);
  localparam int CHW = $clog2(CHANNELS);

  logic [7:0] ctrl_mem [CHANNELS];
  logic [7:0] idle_mem [CHANNELS];
  logic [7:0] dl;
  logic [6:0] lp, pr;
  logic [2:0] mw_idx;

  logic [PW-1:0]  pm1;
  logic [CHW-1:0] chf;
  logic           is_f, ch_ok, ch_end, nx_skip;
  logic [7:0]     cw, idle_c, din_b, lin_b, pin_b, mw, sub, res;
  logic           ins_ok, unf_ins, fr_ins, prbs_used;

  assign pm1     = frm_pos - PW'(1);
  assign chf     = CHW'(pm1 >> 3);
  assign is_f    = (frm_pos == '0);
  assign ch_ok   = !is_f && (chf < CHW'(CHANNELS));
  assign ch_end  = ch_ok && (pm1[2:0] == 3'd7);
  assign nx_skip = nx56 && (pm1[2:0] == 3'd7);
  assign cw      = ch_ok ? ctrl_mem[chf] : 8'h00;
  assign idle_c  = ch_ok ? idle_mem[chf] : IDLE_RST;

  assign din_b = {dl[6:0], ser_in};
  assign lin_b = {lp, loop_in};
  assign pin_b = {pr, prbs_in};

  assign ins_ok    = glb_en && !tap_mode;
  assign unf_ins   = ins_ok && unframed;
  assign fr_ins    = ins_ok && !unframed && cw[3];
  assign prbs_used = fr_ins && !cw[5] && !cw[2];

  always_comb begin
    case (mw_idx)
      3'd0, 3'd3: mw = 8'h1E;
      3'd1, 3'd2: mw = 8'h0B;
      3'd4, 3'd7: mw = 8'h9E;
      default:    mw = 8'h8B;
    endcase
  end

  always_comb begin
    sub = din_b ^ {cw[7], {7{cw[4]}}};
    if (cw[6]) sub = idle_c;
    if (fr_ins) sub = nx56 ? {pin_b[7:1], din_b[0]} : pin_b;
    if (cw[5]) sub = mw;
    if (cw[2]) sub = lin_b;
    res = sub;
    if (!prbs_used) begin
      case (cw[1:0])
        2'd1: if (sub == 8'h00) res = 8'h02;
        2'd2: if (sub == 8'h00) res = 8'h01;
        2'd3: if (sub[6:0] == 7'h00) res = sub | 8'h02;
        default: res = sub;
      endcase
    end
    if (!glb_en) res = din_b;
    if (unf_ins) res = pin_b;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < CHANNELS; i++) begin
        ctrl_mem[i] <= 8'h00;
        idle_mem[i] <= IDLE_RST;
      end
    end else if (cfg_we && cfg_ch < CHW'(CHANNELS)) begin
      if (cfg_sel) idle_mem[cfg_ch] <= cfg_wdata;
      else         ctrl_mem[cfg_ch] <= cfg_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dl      <= '0;
      lp      <= '0;
      pr      <= '0;
      mw_idx  <= '0;
      ser_out <= 1'b0;
      tap_dat <= 1'b0;
      tap_vld <= 1'b0;
    end else if (bit_en) begin
      ser_out <= dl[7];
      lp      <= lin_b[6:0];
      pr      <= pin_b[6:0];
      if (ch_end)
        dl <= res;
      else
        dl <= {dl[6:0], (is_f && unf_ins) ? prbs_in : ser_in};
      if (frm_pos == PW'(FRAME_BITS-1)) mw_idx <= mw_idx + 3'd1;
      tap_dat <= ser_in;
      tap_vld <= glb_en && tap_mode &&
                 (unframed || (ch_ok && cw[3] && !nx_skip));
    end else begin
      tap_vld <= 1'b0;
    end
  end
endmodule

module t1_payload_mod_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic ser_in,
  input logic glb_en,
  input logic tap_mode,
  input logic ser_out,
  input logic tap_dat,
  input logic tap_vld
);
  assert_out_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(ser_out));
  assert_tap_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> !tap_vld);
  assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en |=> !tap_vld);
  assert_tap_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tap_mode |=> !tap_vld);
  assert_tap_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bit_en |=> (tap_dat == $past(ser_in)));
endmodule

bind t1_payload_mod t1_payload_mod_chk chk_i (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ser_in(ser_in),
  .glb_en(glb_en), .tap_mode(tap_mode), .ser_out(ser_out),
  .tap_dat(tap_dat), .tap_vld(tap_vld)
);

// File: tb/t1_payload_mod_test.sv
`timescale 1ns/1ps
module t1_payload_mod_test;
  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0;
  logic [7:0] frm_pos = '0;
  logic ser_in = 0, loop_in = 0, prbs_in = 0;
  logic glb_en = 0, tap_mode = 0, unframed = 0, nx56 = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [4:0] cfg_ch = '0;
  logic [7:0] cfg_wdata = '0;
  logic ser_out, tap_dat, tap_vld;

  t1_payload_mod uut (.*);

  always #2 clk = ~clk;

  int checks = 0, errors = 0, fc = 0;
  logic [31:0] seed = 32'h1234_5677;
  logic [7:0] ctrl_m [24];
  logic [7:0] idle_m [24];
  logic [7:0] di [8][24], li [8][24], pi [8][24], got [8][24];
  logic fd [8], fp [8], gf [8];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] rnd8();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed[7:0];
  endfunction

  function automatic logic [7:0] mw_at(input int i);
    case (i % 8)
      0, 3: return 8'h1E;
      1, 2: return 8'h0B;
      4, 7: return 8'h9E;
      default: return 8'h8B;
    endcase
  endfunction

  function automatic logic [7:0] exp_b(input int c, input logic [7:0] d,
      input logic [7:0] l, input logic [7:0] p, input int idx);
    logic [7:0] w, r;
    bit from_prbs;
    w = ctrl_m[c];
    from_prbs = 0;
    if (!glb_en) return d;
    if (!tap_mode && unframed) return p;
    if (w[2]) r = l;
    else if (w[5]) r = mw_at(idx);
    else if (!tap_mode && w[3]) begin
      r = nx56 ? {p[7:1], d[0]} : p;
      from_prbs = 1;
    end
    else if (w[6]) r = idle_m[c];
    else r = {d[7] ^ w[7], d[6:0] ^ {7{w[4]}}};
    if (!from_prbs) begin
      if (w[1:0] == 2'd1 && r == 8'h00) r = 8'h02;
      else if (w[1:0] == 2'd2 && r == 8'h00) r = 8'h01;
      else if (w[1:0] == 2'd3 && r[6:0] == 7'h00) r = r | 8'h02;
    end
    return r;
  endfunction

  task automatic wr(input bit sel, input int ch, input logic [7:0] v);
    cfg_we = 1; cfg_sel = sel; cfg_ch = 5'(ch); cfg_wdata = v;
    @(posedge clk); @(negedge clk);
    cfg_we = 0;
    if (ch < 24) begin
      if (sel) idle_m[ch] = v; else ctrl_m[ch] = v;
    end
  endtask

  task automatic clr_ctrl();
    for (int c = 0; c < 24; c++) wr(0, c, 8'h00);
  endtask

  task automatic run(input int nf, input logic [23:0] zsel, input bit gaps,
                     input string tag, input string ttag);
    int tmis = 0, gmis = 0;
    logic prev, evld, bv, lv, pv;
    for (int f = 0; f < nf; f++) begin
      logic [7:0] t;
      t = rnd8(); fd[f] = t[0]; fp[f] = t[1];
      for (int c = 0; c < 24; c++) begin
        di[f][c] = zsel[c] ? ((f % 2) ? 8'h80 : 8'h00) : rnd8();
        li[f][c] = rnd8();
        pi[f][c] = rnd8();
      end
    end
    for (int g = 0; g < nf*193 + 8; g++) begin
      int f, p, c, b;
      f = g / 193; p = g % 193; c = (p - 1) / 8; b = (p - 1) % 8;
      if (f < nf) begin
        if (p == 0) begin bv = fd[f]; lv = 0; pv = fp[f]; end
        else begin bv = di[f][c][7-b]; lv = li[f][c][7-b]; pv = pi[f][c][7-b]; end
      end else begin bv = 0; lv = 0; pv = 0; end
      bit_en = 1; frm_pos = 8'(p); ser_in = bv; loop_in = lv; prbs_in = pv;
      @(posedge clk); @(negedge clk);
      if (g >= 8) begin
        int k, kf, kp;
        k = g - 8; kf = k / 193; kp = k % 193;
        if (kp == 0) gf[kf] = ser_out;
        else got[kf][(kp-1)/8] = {got[kf][(kp-1)/8][6:0], ser_out};
      end
      if (f < nf) begin
        evld = glb_en && tap_mode &&
               (unframed || (p != 0 && ctrl_m[c][3] && !(nx56 && b == 7)));
        if (tap_vld !== evld || (evld && tap_dat !== bv)) tmis++;
      end
      prev = ser_out;
      if (gaps) begin
        bit_en = 0;
        @(posedge clk); @(negedge clk);
        if (ser_out !== prev || tap_vld !== 1'b0) gmis++;
      end
    end
    bit_en = 0;
    for (int f = 0; f < nf; f++) begin
      logic ef;
      ef = (glb_en && !tap_mode && unframed) ? fp[f] : fd[f];
      chk(gf[f] === ef, (glb_en && !tap_mode && unframed) ? "R9 frame bit" : "R3 frame bit",
          int'(gf[f]), int'(ef));
      for (int c = 0; c < 24; c++) begin
        logic [7:0] e;
        e = exp_b(c, di[f][c], li[f][c], pi[f][c], fc + f);
        chk(got[f][c] === e, $sformatf("%s frame %0d ch %0d", tag, f, c),
            int'(got[f][c]), int'(e));
      end
    end
    chk(tmis == 0, $sformatf("%s tap mismatches", ttag), tmis, 0);
    if (gaps) chk(gmis == 0, "R2 hold between strobes", gmis, 0);
    fc += nf;
  endtask

  task automatic t_reset();
    chk(ser_out === 1'b0, "R1 ser_out after reset", int'(ser_out), 0);
    chk(tap_vld === 1'b0, "R1 tap_vld after reset", int'(tap_vld), 0);
    glb_en = 1;
    wr(0, 0, 8'h40);
    wr(0, 1, 8'h20);
    run(1, 24'h0, 0, "R1 default idle and milliwatt index", "R1");
    clr_ctrl();
  endtask

  task automatic t_gate();
    glb_en = 0;
    for (int c = 0; c < 24; c++) wr(0, c, 8'(8'hF8 + c));
    tap_mode = 1;
    run(1, 24'h0, 0, "R4 global enable off", "R4");
    tap_mode = 0;
    glb_en = 1;
    clr_ctrl();
  endtask

  task automatic t_priority();
    wr(0, 0, 8'h04);  wr(0, 1, 8'h20);  wr(0, 2, 8'h24);  wr(0, 3, 8'h08);
    wr(0, 4, 8'h48);  wr(0, 5, 8'h40);  wr(0, 6, 8'h80);  wr(0, 7, 8'h10);
    wr(0, 8, 8'h90);  wr(0, 9, 8'h28);  wr(0, 10, 8'hC0); wr(0, 11, 8'h2C);
    wr(0, 12, 8'h0C); wr(0, 13, 8'hC4);
    wr(1, 4, 8'h5A);  wr(1, 5, 8'hA5);  wr(1, 10, 8'h3C);
    wr(0, 24, 8'h24); wr(0, 29, 8'h40); wr(1, 31, 8'h00); wr(0, 30, 8'h08);
    run(8, 24'h0, 0, "R5 R6 R7 R12 priority", "R11");
    clr_ctrl();
  endtask

  task automatic t_zcs();
    wr(0, 0, 8'h01); wr(0, 1, 8'h02); wr(0, 2, 8'h03); wr(0, 3, 8'h09);
    wr(0, 4, 8'h43); wr(1, 4, 8'h80); wr(0, 5, 8'h81); wr(0, 6, 8'h00);
    wr(0, 7, 8'h13);
    run(2, 24'h0000FF, 0, "R10 zero code", "R11");
    clr_ctrl();
  endtask

  task automatic t_nx56();
    nx56 = 1;
    for (int c = 0; c < 24; c += 3) wr(0, c, 8'h08);
    wr(0, 1, 8'h48);
    run(1, 24'h0, 0, "R8 fractional insert", "R11");
    nx56 = 0;
  endtask

  task automatic t_unframed();
    unframed = 1;
    wr(0, 2, 8'h04); wr(0, 5, 8'h20);
    run(2, 24'h0, 0, "R9 unframed insert", "R11");
    unframed = 0;
    clr_ctrl();
  endtask

  task automatic t_tap();
    tap_mode = 1; nx56 = 1;
    for (int c = 0; c < 24; c += 2) wr(0, c, 8'h08);
    wr(0, 1, 8'h28);
    run(1, 24'h0, 0, "R11 framed tap output", "R11 framed");
    nx56 = 0; unframed = 1;
    run(1, 24'h0, 0, "R11 unframed tap output", "R11 unframed");
    unframed = 0; tap_mode = 0;
    clr_ctrl();
  endtask

  task automatic t_gaps();
    wr(0, 3, 8'h80); wr(0, 4, 8'h20); wr(0, 9, 8'h08);
    run(1, 24'h0, 1, "R2 strobe gaps", "R2");
    clr_ctrl();
  endtask

  initial begin
    for (int c = 0; c < 24; c++) begin ctrl_m[c] = 8'h00; idle_m[c] = 8'h7F; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    t_reset();
    t_gate();
    t_priority();
    t_zcs();
    t_nx56();
    t_unframed();
    t_tap();
    t_gaps();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule